// File: doc/BRIEF.md
# Burst Stealing-Flag Sequencer

This block walks a signalling block across the consecutive radio bursts that carry it and, for each burst, presents the pair of stealing flags (upper flag `hu`, lower flag `hl`) that mark the burst as carrying control data. Three channel modes are supported: a slow associated channel, a full-rate fast associated channel and a half-rate fast associated channel. The mode determines both how many bursts the block occupies and which flag pattern each burst carries.

A one-cycle start pulse, qualified by the mode code, opens a sequence and presents burst 0. Each burst strobe moves the outputs on to the next burst. The strobe that arrives while the final burst is presented closes the sequence. All outputs are registered. They describe the burst currently being prepared, so a burst formatter downstream can read them at any time between strobes. Alongside the flags the block gives the burst index, two indications of which interleaved bit positions (even and odd) the control block occupies, and a done flag.

Top module: `steal_flag_seq`

## Requirements
- R1: After reset, `hu_o`, `hl_o`, `even_used_o`, `odd_used_o` and `done_o` are 0 and `burst_idx_o` is 0.
- R2: A start pulse with mode code 0 (slow), 1 (full-rate fast) or 2 (half-rate fast) presents burst 0 of that mode one cycle later. The mode is captured only at start, so changes on `mode_i` during a sequence have no effect.
- R3: While a sequence is active, each strobe advances `burst_idx_o` by one in the following cycle and the outputs hold between strobes. A strobe with no active sequence is ignored.
- R4: In slow mode (code 0) the sequence spans 4 bursts, and `hu_o` and `hl_o` are both 1 on each of them.
- R5: In full-rate mode (code 1) the sequence spans 8 bursts: `hu_o`=1, `hl_o`=0 on bursts 0 to 3, and `hu_o`=0, `hl_o`=1 on bursts 4 to 7.
- R6: In half-rate mode (code 2) the sequence spans 6 bursts: only `hu_o` on bursts 0 and 1, both flags on bursts 2 and 3, and only `hl_o` on bursts 4 and 5.
- R7: `even_used_o` is 1 exactly when the presented burst carries control data in its even bit positions (same bursts as `hu_o`=1), and `odd_used_o` is 1 exactly for the odd positions (same bursts as `hl_o`=1).
- R8: `done_o` is 1 exactly while the final burst of the mode is presented. A strobe in that state ends the sequence: flags, indications and `done_o` become 0, and `burst_idx_o` keeps its last value.
- R9: A start pulse during an active sequence restarts it at burst 0 with the newly sampled mode, and it takes priority over a strobe in the same cycle.
- R10: A start pulse with the reserved mode code 3 is ignored. An idle block stays idle, and an active sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse opening a new sequence |
| mode_i | input | 2 | Channel mode code: 0 slow, 1 full-rate fast, 2 half-rate fast, 3 reserved |
| strobe_i | input | 1 | Burst strobe; advances the active sequence by one burst |
| hu_o | output | 1 | Upper stealing flag of the presented burst |
| hl_o | output | 1 | Lower stealing flag of the presented burst |
| burst_idx_o | output | IDX_W (3) | Index of the presented burst within the sequence |
| even_used_o | output | 1 | Control data sits in the even bit positions of this burst |
| odd_used_o | output | 1 | Control data sits in the odd bit positions of this burst |
| done_o | output | 1 | The presented burst is the last of the sequence |

## Verification
Each mode is run end to end with strobes back to back and with idle gaps between them. This separates a sequencer that advances on the strobe from one that advances on the clock, and it shows where the flag boundaries fall in the 8-burst and 6-burst patterns. A full-rate run with `mode_i` changed partway through shows whether the mode is sampled only at start. Restart pulses issued mid-sequence, on the final burst and together with a strobe test start priority. Reserved-code starts given while idle and while active, and strobes given after a sequence has ended, show that ignored stimulus leaves the flags and the held index untouched.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [1:0] {
    CH_SLOW = 2'd0,
    CH_FULL = 2'd1,
    CH_HALF = 2'd2,
    CH_RSVD = 2'd3
  } chan_mode_e;

endpackage

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int SLOW_LEN = 4,
  parameter int FULL_LEN = 8,
  parameter int HALF_LEN = 6,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             strobe_i,
  output logic             nxt_act_o,
  output chan_mode_e       nxt_mode_o,
  output logic [IDX_W-1:0] nxt_idx_o,
  output logic             nxt_last_o,
  output logic             cur_act_o,
  output chan_mode_e       cur_mode_o
);

  localparam logic [IDX_W-1:0] SLOW_LAST = IDX_W'(SLOW_LEN - 1);
  localparam logic [IDX_W-1:0] FULL_LAST = IDX_W'(FULL_LEN - 1);
  localparam logic [IDX_W-1:0] HALF_LAST = IDX_W'(HALF_LEN - 1);

  logic             act_q;
  chan_mode_e       mode_q;
  logic [IDX_W-1:0] idx_q;
  logic             cur_last;
  logic             go;

  function automatic logic [IDX_W-1:0] last_of(chan_mode_e m);
    case (m)
      CH_FULL: last_of = FULL_LAST;
      CH_HALF: last_of = HALF_LAST;
      default: last_of = SLOW_LAST;
    endcase
  endfunction

  assign cur_last = (idx_q == last_of(mode_q));
  assign go       = start_i && (chan_mode_e'(mode_i) != CH_RSVD);

  always_comb begin
    nxt_act_o  = act_q;
    nxt_mode_o = mode_q;
    nxt_idx_o  = idx_q;
    if (go) begin
      nxt_act_o  = 1'b1;
      nxt_mode_o = chan_mode_e'(mode_i);
      nxt_idx_o  = '0;
    end else if (act_q && strobe_i) begin
      if (cur_last) nxt_act_o = 1'b0;
      else          nxt_idx_o = idx_q + 1'b1;
    end
    nxt_last_o = (nxt_idx_o == last_of(nxt_mode_o));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      mode_q <= CH_SLOW;
      idx_q  <= '0;
    end else begin
      act_q  <= nxt_act_o;
      mode_q <= nxt_mode_o;
      idx_q  <= nxt_idx_o;
    end
  end

  assign cur_act_o  = act_q;
  assign cur_mode_o = mode_q;

  // R10: a reserved start on an idle block keeps it idle
  p_rsvd_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!act_q && start_i && chan_mode_e'(mode_i) == CH_RSVD) |=> !act_q);

  // R2: mode is held for the whole sequence when no start arrives
  p_mode_held_r2: assert property (@(posedge clk) disable iff (rst)
    (act_q && !start_i) |=> (mode_q == $past(mode_q)));

endmodule

// File: rtl/sfs_flag_dec.sv
module sfs_flag_dec
  import sfs_pkg::*;
#(
  parameter int FULL_LEN = 8,
  parameter int HALF_LEN = 6,
  parameter int IDX_W    = 3
) (
  input  logic             act_i,
  input  chan_mode_e       mode_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             even_use_o,
  output logic             odd_use_o
);

  localparam int FULL_SPLIT = FULL_LEN / 2;
  localparam int HALF_EDGE  = HALF_LEN / 3;
  localparam logic [IDX_W-1:0] FULL_SPLIT_I = IDX_W'(FULL_SPLIT);
  localparam logic [IDX_W-1:0] HALF_EVEN_END = IDX_W'(HALF_LEN - HALF_EDGE);
  localparam logic [IDX_W-1:0] HALF_ODD_BEG  = IDX_W'(HALF_EDGE);

  always_comb begin
    even_use_o = 1'b0;
    odd_use_o  = 1'b0;
    if (act_i) begin
      case (mode_i)
        CH_SLOW: begin
          even_use_o = 1'b1;
          odd_use_o  = 1'b1;
        end
        CH_FULL: begin
          even_use_o = (idx_i <  FULL_SPLIT_I);
          odd_use_o  = (idx_i >= FULL_SPLIT_I);
        end
        CH_HALF: begin
          even_use_o = (idx_i <  HALF_EVEN_END);
          odd_use_o  = (idx_i >= HALF_ODD_BEG);
        end
        default: begin
          even_use_o = 1'b0;
          odd_use_o  = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/steal_flag_seq.sv
module steal_flag_seq
  import sfs_pkg::*;
#(
  parameter int SLOW_LEN = 4,
  parameter int FULL_LEN = 8,
  parameter int HALF_LEN = 6,
  parameter int MAX_LEN  = (FULL_LEN > HALF_LEN) ? ((FULL_LEN > SLOW_LEN) ? FULL_LEN : SLOW_LEN)
                                                 : ((HALF_LEN > SLOW_LEN) ? HALF_LEN : SLOW_LEN),
  parameter int IDX_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             strobe_i,
  output logic             hu_o,
  output logic             hl_o,
  output logic [IDX_W-1:0] burst_idx_o,
  output logic             even_used_o,
  output logic             odd_used_o,
  output logic             done_o
);

  logic             nxt_act;
  chan_mode_e       nxt_mode;
  logic [IDX_W-1:0] nxt_idx;
  logic             nxt_last;
  logic             cur_act;
  chan_mode_e       cur_mode;
  logic             even_use;
  logic             odd_use;

  sfs_ctrl #(
    .SLOW_LEN(SLOW_LEN),
    .FULL_LEN(FULL_LEN),
    .HALF_LEN(HALF_LEN),
    .IDX_W   (IDX_W)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .strobe_i  (strobe_i),
    .nxt_act_o (nxt_act),
    .nxt_mode_o(nxt_mode),
    .nxt_idx_o (nxt_idx),
    .nxt_last_o(nxt_last),
    .cur_act_o (cur_act),
    .cur_mode_o(cur_mode)
  );

  sfs_flag_dec #(
    .FULL_LEN(FULL_LEN),
    .HALF_LEN(HALF_LEN),
    .IDX_W   (IDX_W)
  ) dec_i (
    .act_i     (nxt_act),
    .mode_i    (nxt_mode),
    .idx_i     (nxt_idx),
    .even_use_o(even_use),
    .odd_use_o (odd_use)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hu_o        <= 1'b0;
      hl_o        <= 1'b0;
      even_used_o <= 1'b0;
      odd_used_o  <= 1'b0;
      done_o      <= 1'b0;
      burst_idx_o <= '0;
    end else begin
      hu_o        <= even_use;
      hl_o        <= odd_use;
      even_used_o <= even_use;
      odd_used_o  <= odd_use;
      done_o      <= nxt_act && nxt_last;
      burst_idx_o <= nxt_idx;
    end
  end

  // R2: a valid start presents burst 0 with at least one flag
  p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && chan_mode_e'(mode_i) != CH_RSVD) |=> (burst_idx_o == '0 && (hu_o || hl_o)));

  // R3: a strobe on a non-final burst advances the index by one
  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (cur_act && strobe_i && !start_i && !done_o) |=> (burst_idx_o == $past(burst_idx_o) + 1'b1));

  // R3: without start or strobe the presented burst does not move
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !strobe_i) |=> ($stable(burst_idx_o) && $stable(hu_o) && $stable(hl_o)));

  // R4: slow mode sets both flags on every burst
  p_slow_both_r4: assert property (@(posedge clk) disable iff (rst)
    (cur_act && cur_mode == CH_SLOW) |-> (hu_o && hl_o));

  // R7: every presented burst uses at least one bit parity
  p_some_use_r7: assert property (@(posedge clk) disable iff (rst)
    cur_act |-> (even_used_o || odd_used_o));

  // R8: strobe on the final burst ends the sequence and keeps the index
  p_done_end_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && strobe_i && !start_i) |=> (!hu_o && !hl_o && !done_o && $stable(burst_idx_o)));

  // R8: with no sequence active, nothing is flagged
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !cur_act |-> (!hu_o && !hl_o && !done_o));

endmodule

// File: tb/steal_flag_seq_tb_top.sv
module steal_flag_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       start_i;
  logic [1:0] mode_i;
  logic       strobe_i;
  logic       hu_o, hl_o, even_used_o, odd_used_o, done_o;
  logic [2:0] burst_idx_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit ended = 1'b0;

  // reference model state
  bit m_act = 1'b0;
  int m_mode = 0;
  int m_idx = 0;

  always #4 clk = ~clk;

  steal_flag_seq dut_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .strobe_i   (strobe_i),
    .hu_o       (hu_o),
    .hl_o       (hl_o),
    .burst_idx_o(burst_idx_o),
    .even_used_o(even_used_o),
    .odd_used_o (odd_used_o),
    .done_o     (done_o)
  );

  function automatic int seq_len(int m);
    if (m == 1) return 8;
    if (m == 2) return 6;
    return 4;
  endfunction

  function automatic bit exp_hu();
    if (!m_act) return 1'b0;
    if (m_mode == 0) return 1'b1;
    return (m_idx < 4);
  endfunction

  function automatic bit exp_hl();
    if (!m_act) return 1'b0;
    if (m_mode == 0) return 1'b1;
    if (m_mode == 1) return (m_idx >= 4);
    return (m_idx >= 2);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string ctx);
    string ftag;
    ftag = !m_act ? "R8" : (m_mode == 0) ? "R4" : (m_mode == 1) ? "R5" : "R6";
    chk({ftag, " ", ctx}, "hu", hu_o, exp_hu());
    chk({ftag, " ", ctx}, "hl", hl_o, exp_hl());
    chk({"R7 ", ctx}, "even_used", even_used_o, exp_hu());
    chk({"R7 ", ctx}, "odd_used", odd_used_o, exp_hl());
    chk({"R3 ", ctx}, "burst_idx", burst_idx_o, m_idx);
    chk({"R8 ", ctx}, "done", done_o, (m_act && m_idx == seq_len(m_mode) - 1));
  endtask

  task automatic step(bit s, logic [1:0] m, bit b, string ctx);
    start_i  = s;
    mode_i   = m;
    strobe_i = b;
    @(posedge clk);
    if (rst) begin
      m_act = 1'b0; m_idx = 0;
    end else if (s && m != 2'd3) begin
      m_act = 1'b1; m_mode = int'(m); m_idx = 0;
    end else if (m_act && b) begin
      if (m_idx == seq_len(m_mode) - 1) m_act = 1'b0;
      else m_idx++;
    end
    #2;
    compare(ctx);
    @(negedge clk);
  endtask

  task automatic run_seq(int m, int gap, string ctx);
    step(1'b1, 2'(m), 1'b0, ctx);
    for (int i = 0; i < seq_len(m); i++) begin
      for (int g = 0; g < gap; g++) step(1'b0, 2'(m), 1'b0, ctx);
      step(1'b0, 2'(m), 1'b1, ctx);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !ended) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; mode_i = 2'd0; strobe_i = 1'b0;
    @(negedge clk);
    step(1'b0, 2'd0, 1'b0, "reset");
    step(1'b0, 2'd0, 1'b0, "reset");
    rst = 1'b0;
    // R1: reset state observed right after release
    step(1'b0, 2'd0, 1'b0, "R1 after reset");
    // R3: strobe with nothing active is ignored
    step(1'b0, 2'd1, 1'b1, "R3 idle strobe");
    // R10: reserved code while idle
    step(1'b1, 2'd3, 1'b0, "R10 idle reserved start");
    step(1'b0, 2'd3, 1'b1, "R10 idle reserved strobe");
    // R4 slow mode, back-to-back and with gaps
    run_seq(0, 0, "R4 slow b2b");
    run_seq(0, 2, "R4 slow gap");
    step(1'b0, 2'd0, 1'b1, "R8 strobe after end");
    // R5 full rate
    run_seq(1, 0, "R5 full b2b");
    run_seq(1, 1, "R5 full gap");
    // R6 half rate
    run_seq(2, 0, "R6 half b2b");
    run_seq(2, 3, "R6 half gap");
    // R2: mode changes mid-sequence do not matter
    step(1'b1, 2'd1, 1'b0, "R2 full start");
    for (int i = 0; i < 8; i++) step(1'b0, 2'(i % 3), 1'b1, "R2 mode wiggle");
    // R9: restart mid-sequence, with a simultaneous strobe
    step(1'b1, 2'd2, 1'b0, "R9 half start");
    step(1'b0, 2'd2, 1'b1, "R9 adv");
    step(1'b0, 2'd2, 1'b1, "R9 adv");
    step(1'b1, 2'd0, 1'b1, "R9 restart slow with strobe");
    step(1'b0, 2'd0, 1'b1, "R9 adv");
    // R10: reserved start while active leaves the sequence running
    step(1'b1, 2'd3, 1'b0, "R10 active reserved start");
    step(1'b1, 2'd3, 1'b1, "R10 active reserved with strobe");
    step(1'b0, 2'd0, 1'b1, "R10 continue");
    // R9: restart exactly on the final burst
    run_seq(1, 0, "R9 full");
    step(1'b1, 2'd2, 1'b0, "R9 half");
    for (int i = 0; i < 5; i++) step(1'b0, 2'd2, 1'b1, "R9 to last");
    step(1'b1, 2'd1, 1'b1, "R9 restart on last");
    for (int i = 0; i < 9; i++) step(1'b0, 2'd1, 1'b1, "R5 after restart");
    // R1: reset in the middle of a sequence
    step(1'b1, 2'd2, 1'b0, "R6 pre-reset");
    step(1'b0, 2'd2, 1'b1, "R6 pre-reset");
    rst = 1'b1;
    step(1'b0, 2'd2, 1'b1, "R1 mid reset");
    rst = 1'b0;
    step(1'b0, 2'd2, 1'b1, "R1 after mid reset");
    finish_run();
  end

endmodule